// File: doc/BRIEF.md
# USB Host Frame Control Registers

This block holds the command, status, interrupt-enable, frame-number and frame-list-base registers of a host controller for USB 1.x that walks a 1024-entry frame list in memory. Software reaches it through a single-cycle register port: a write is taken on the clock edge where `reg_wr` is high, and a read is a combinational decode of `reg_addr`. A 1 kHz `frame_tick` from the timing logic marks frame boundaries. Descriptor-execution logic elsewhere reports per-frame events on single-cycle pulse inputs.

The block keeps the run/halt state and the 11-bit frame counter. It generates the address of the current frame-list entry for the fetch engine. Completion and short-packet events are held until the next frame boundary, then posted into a two-bit internal latch and the sticky interrupt flag. Error conditions and resume requests feed the same interrupt combiner, and that combiner drives a level interrupt line. A start request counts as a frame boundary on its own, so processing begins without waiting for the next tick.

Top module: `usbh_frame_regs`

Register indexes on `reg_addr`: 0 command, 1 status, 2 interrupt enable, 3 frame number, 4 list base. All other indexes read as zero.

## Requirements
- R1: After reset, `halted` is 1. Command, interrupt enable, frame number and list base read 0. Status reads 0x20 (bit 5 is the halted flag). `irq` is 0.
- R2: A command write with bit 0 (run) = 1 while run is 0 clears `halted` on the capturing edge. A command write with bit 0 = 0 sets it. A frame tick while run is 0 also sets it.
- R3: The edge after a 0-to-1 run write is a frame boundary. From then on, each frame tick while run is 1 is a boundary. A boundary adds 1 to the frame number modulo 2048.
- R4: While run is 0, frame ticks leave the frame number unchanged.
- R5: A frame-number write (bits 10:0) takes effect only while halted. While running it is ignored.
- R6: A list-base write stores the data with bits 11:0 forced to 0. `list_entry_addr` equals the base OR (frame number bits 9:0 shifted left by 2).
- R7: `td_ioc` and `td_spd` pulses are held pending, with no visible effect, until the next frame boundary. At the boundary they set hidden bit 0 (completion) or hidden bit 1 (short packet), and status bit 0.
- R8: `irq` is high exactly when at least one of these holds:
  - hidden bit 0 and enable bit 2;
  - hidden bit 1 and enable bit 3;
  - status bit 1 and enable bit 0;
  - status bit 2 and enable bit 1;
  - status bit 3;
  - status bit 4.
- R9: Writing 1 to status bits 4:0 clears them. Writing 1 to bit 0 also clears both hidden bits. Bit 5 ignores writes. An event in the same cycle as the clear wins.
- R10: `td_err`, `sys_err` and `proc_err` set status bits 1, 3 and 4 respectively, and those bits stay set.
- R11: A `resume_req` pulse while command bit 3 (suspend) is 1 sets command bit 4 (force resume) and status bit 2. With bit 3 at 0 it has no effect.
- R12: A command write with bit 1 set returns every register to its R1 value. Bit 1 always reads 0. Command bit 2 is stored and read back with no other effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW (3) | Register index |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Read data for `reg_addr` |
| frame_tick | input | 1 | Frame boundary pulse (1 kHz) |
| resume_req | input | 1 | Remote resume request pulse |
| td_ioc | input | 1 | Completion-interrupt event from descriptor processing |
| td_spd | input | 1 | Short-packet event from descriptor processing |
| td_err | input | 1 | Transfer error event |
| sys_err | input | 1 | Host system error event |
| proc_err | input | 1 | Schedule processing error event |
| halted | output | 1 | Controller halted |
| list_entry_addr | output | DATA_W (32) | Address of the current frame-list entry |
| irq | output | 1 | Level interrupt |

## Verification
A wrong run/halt flop shows up on `halted` and on status bit 5 on the edge after the offending write or tick. A miscounted frame number shows up on `list_entry_addr` on the very next boundary, because the address is combinational from the counter. Lost or early posting of pending events shows up on status bit 0 and `irq` at the boundary cycle rather than one cycle later. A wrong hidden-latch routing is exposed only when just one of enable bits 2 and 3 is set. For that reason the stimulus changes the enables between completion and short-packet events.

// File: rtl/usbh_frm_pkg.sv
package usbh_frm_pkg;

   typedef enum logic [2:0] {
      RA_CMD  = 3'd0,
      RA_STS  = 3'd1,
      RA_IEN  = 3'd2,
      RA_FNUM = 3'd3,
      RA_BASE = 3'd4
   } reg_idx_e;

   // command bits
   localparam int CB_RUN   = 0;
   localparam int CB_HCRST = 1;
   localparam int CB_GRST  = 2;
   localparam int CB_SUSP  = 3;
   localparam int CB_FRES  = 4;

   // status bits (bit 5 is the halted flag, held outside the sticky vector)
   localparam int SB_INT  = 0;
   localparam int SB_ERR  = 1;
   localparam int SB_RES  = 2;
   localparam int SB_HSE  = 3;
   localparam int SB_PERR = 4;

   // interrupt enable bits
   localparam int EB_ERR = 0;
   localparam int EB_RES = 1;
   localparam int EB_IOC = 2;
   localparam int EB_SPD = 3;

   localparam int CMD_W = 5;
   localparam int STS_W = 5;
   localparam int IEN_W = 4;
   localparam int HID_W = 2;

endpackage

// File: rtl/usbh_frm_ctrl.sv
module usbh_frm_ctrl
   import usbh_frm_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_cmd,
   input  logic             wr_sts,
   input  logic             wr_ien,
   input  logic [CMD_W-1:0] wdata,
   input  logic             frame_tick,
   input  logic             resume_req,
   input  logic             ev_ioc,
   input  logic             ev_spd,
   input  logic             ev_usberr,
   input  logic             ev_hse,
   input  logic             ev_perr,
   output logic [CMD_W-1:0] cmd_q,
   output logic [STS_W-1:0] sts_q,
   output logic [IEN_W-1:0] ien_q,
   output logic [HID_W-1:0] hid_q,
   output logic             halted_q,
   output logic             step,
   output logic             hc_clear
);

   localparam logic [CMD_W-1:0] CMD_KEEP = ~(CMD_W'(1) << CB_HCRST);

   logic             start_q;
   logic [HID_W-1:0] pend_q;

   logic [CMD_W-1:0] cmd_n;
   logic [STS_W-1:0] sts_n;
   logic [IEN_W-1:0] ien_n;
   logic [HID_W-1:0] hid_n;
   logic [HID_W-1:0] pend_n;
   logic             halt_n;
   logic             start_n;

   assign hc_clear = wr_cmd & wdata[CB_HCRST];
   assign step     = start_q | (frame_tick & cmd_q[CB_RUN]);

   always_comb begin
      cmd_n   = cmd_q;
      sts_n   = sts_q;
      ien_n   = ien_q;
      hid_n   = hid_q;
      pend_n  = pend_q;
      halt_n  = halted_q;
      start_n = 1'b0;

      if (frame_tick && !cmd_q[CB_RUN])
         halt_n = 1'b1;

      if (wr_cmd) begin
         cmd_n = wdata & CMD_KEEP;
         if (wdata[CB_RUN] && !cmd_q[CB_RUN]) begin
            halt_n  = 1'b0;
            start_n = 1'b1;
         end else if (!wdata[CB_RUN]) begin
            halt_n = 1'b1;
         end
      end

      if (wr_sts) begin
         sts_n = sts_q & ~wdata[STS_W-1:0];
         if (wdata[SB_INT])
            hid_n = '0;
      end

      if (wr_ien)
         ien_n = wdata[IEN_W-1:0];

      if (step) begin
         pend_n = '0;
         if (|pend_q) begin
            hid_n         = hid_n | pend_q;
            sts_n[SB_INT] = 1'b1;
         end
      end

      pend_n         = pend_n | {ev_spd, ev_ioc};
      sts_n[SB_ERR]  = sts_n[SB_ERR]  | ev_usberr;
      sts_n[SB_HSE]  = sts_n[SB_HSE]  | ev_hse;
      sts_n[SB_PERR] = sts_n[SB_PERR] | ev_perr;

      if (resume_req && cmd_q[CB_SUSP]) begin
         cmd_n[CB_FRES] = 1'b1;
         sts_n[SB_RES]  = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q    <= '0;
         sts_q    <= '0;
         ien_q    <= '0;
         hid_q    <= '0;
         pend_q   <= '0;
         halted_q <= 1'b1;
         start_q  <= 1'b0;
      end else if (hc_clear) begin
         cmd_q    <= '0;
         sts_q    <= '0;
         ien_q    <= '0;
         hid_q    <= '0;
         pend_q   <= '0;
         halted_q <= 1'b1;
         start_q  <= 1'b0;
      end else begin
         cmd_q    <= cmd_n;
         sts_q    <= sts_n;
         ien_q    <= ien_n;
         hid_q    <= hid_n;
         pend_q   <= pend_n;
         halted_q <= halt_n;
         start_q  <= start_n;
      end
   end

   // R12: controller reset brings every field back to default
   p_hcreset_defaults_r12: assert property (@(posedge clk) disable iff (!rst_n)
      hc_clear |=> (halted_q && cmd_q == '0 && sts_q == '0 && ien_q == '0 && hid_q == '0));

   // R2: a rising run write leaves the controller running
   p_run_clears_halt_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_cmd && wdata[CB_RUN] && !wdata[CB_HCRST] && !cmd_q[CB_RUN]) |=> !halted_q);

   // R10: host system error is sticky once seen
   p_hse_sets_status_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_hse && !hc_clear) |=> sts_q[SB_HSE]);

   // R7: pending events never reach the latch without a boundary
   p_no_post_without_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !wr_sts && !ev_usberr && !ev_hse && !ev_perr && !resume_req && !hc_clear)
         |=> $stable(sts_q));

endmodule

// File: rtl/usbh_frm_counter.sv
module usbh_frm_counter #(
   parameter int DATA_W  = 32,
   parameter int FRNUM_W = 11,
   parameter int IDX_W   = 10,
   parameter int ALIGN_W = 12
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      clear,
   input  logic                      step,
   input  logic                      halted,
   input  logic                      fn_wr,
   input  logic [FRNUM_W-1:0]        fn_wdata,
   input  logic                      base_wr,
   input  logic [DATA_W-ALIGN_W-1:0] base_wdata,
   output logic [FRNUM_W-1:0]        frnum_q,
   output logic [DATA_W-1:0]         base_out,
   output logic [DATA_W-1:0]         entry_addr
);

   localparam int PAD_W = ALIGN_W - IDX_W - 2;

   logic [DATA_W-ALIGN_W-1:0] base_hi_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frnum_q   <= '0;
         base_hi_q <= '0;
      end else if (clear) begin
         frnum_q   <= '0;
         base_hi_q <= '0;
      end else begin
         if (step)
            frnum_q <= frnum_q + 1'b1;
         else if (fn_wr && halted)
            frnum_q <= fn_wdata;
         if (base_wr)
            base_hi_q <= base_wdata;
      end
   end

   assign base_out = {base_hi_q, {ALIGN_W{1'b0}}};

   generate
      if (PAD_W == 0) begin : g_tight
         assign entry_addr = {base_hi_q, frnum_q[IDX_W-1:0], 2'b00};
      end else begin : g_padded
         assign entry_addr = {base_hi_q, {PAD_W{1'b0}}, frnum_q[IDX_W-1:0], 2'b00};
      end
   endgenerate

   // R3: every boundary adds exactly one, wrapping at the counter width
   p_step_advances_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !clear) |=> frnum_q == FRNUM_W'($past(frnum_q) + 1'b1));

   // R5: frame-number writes while running leave the counter untouched
   p_fnum_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (fn_wr && !halted && !step && !clear) |=> $stable(frnum_q));

endmodule

// File: rtl/usbh_frm_irq.sv
module usbh_frm_irq
   import usbh_frm_pkg::*;
#(
   parameter bit REG_OUT = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [STS_W-1:0] sts,
   input  logic [HID_W-1:0] hid,
   input  logic [IEN_W-1:0] ien,
   output logic             irq
);

   logic level;

   assign level = (hid[0] & ien[EB_IOC]) |
                  (hid[1] & ien[EB_SPD]) |
                  (sts[SB_ERR] & ien[EB_ERR]) |
                  (sts[SB_RES] & ien[EB_RES]) |
                  sts[SB_HSE] | sts[SB_PERR];

   generate
      if (REG_OUT) begin : g_flop
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= level;
         end
         assign irq = irq_q;
      end else begin : g_comb
         logic unused_clkrst;
         assign unused_clkrst = clk ^ rst_n;
         assign irq = level;
      end
   endgenerate

   // R8: system-level errors always raise the line
   p_fatal_raises_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (sts[SB_HSE] || sts[SB_PERR]) |-> (REG_OUT ? 1'b1 : irq));

endmodule

// File: rtl/usbh_frame_regs.sv
module usbh_frame_regs
   import usbh_frm_pkg::*;
#(
   parameter int AW         = 3,
   parameter int DATA_W     = 32,
   parameter int FRNUM_W    = 11,
   parameter int IDX_W      = 10,
   parameter int ALIGN_W    = 12,
   parameter bit IRQ_REG    = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [AW-1:0]     reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              frame_tick,
   input  logic              resume_req,
   input  logic              td_ioc,
   input  logic              td_spd,
   input  logic              td_err,
   input  logic              sys_err,
   input  logic              proc_err,
   output logic              halted,
   output logic [DATA_W-1:0] list_entry_addr,
   output logic              irq
);

   generate
      if (AW < 3)                 begin : g_chk_aw   $error("AW must reach five registers"); end
      if (IDX_W >= FRNUM_W)       begin : g_chk_idx  $error("index must be narrower than frame number"); end
      if (ALIGN_W < IDX_W + 2)    begin : g_chk_aln  $error("base alignment must cover the entry offset"); end
      if (DATA_W <= ALIGN_W)      begin : g_chk_dw   $error("data width must exceed base alignment"); end
      if (FRNUM_W > ALIGN_W)      begin : g_chk_fn   $error("frame number must fit below base field"); end
   endgenerate

   logic [CMD_W-1:0]   cmd_q;
   logic [STS_W-1:0]   sts_q;
   logic [IEN_W-1:0]   ien_q;
   logic [HID_W-1:0]   hid_q;
   logic               halted_q;
   logic               step;
   logic               hc_clear;
   logic [FRNUM_W-1:0] frnum_q;
   logic [DATA_W-1:0]  base_q;

   logic wr_cmd, wr_sts, wr_ien, wr_fnum, wr_base;
   logic unused_wdata;

   assign wr_cmd  = reg_wr && (reg_addr == AW'(RA_CMD));
   assign wr_sts  = reg_wr && (reg_addr == AW'(RA_STS));
   assign wr_ien  = reg_wr && (reg_addr == AW'(RA_IEN));
   assign wr_fnum = reg_wr && (reg_addr == AW'(RA_FNUM));
   assign wr_base = reg_wr && (reg_addr == AW'(RA_BASE));
   assign unused_wdata = ^reg_wdata;

   usbh_frm_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_cmd     (wr_cmd),
      .wr_sts     (wr_sts),
      .wr_ien     (wr_ien),
      .wdata      (reg_wdata[CMD_W-1:0]),
      .frame_tick (frame_tick),
      .resume_req (resume_req),
      .ev_ioc     (td_ioc),
      .ev_spd     (td_spd),
      .ev_usberr  (td_err),
      .ev_hse     (sys_err),
      .ev_perr    (proc_err),
      .cmd_q      (cmd_q),
      .sts_q      (sts_q),
      .ien_q      (ien_q),
      .hid_q      (hid_q),
      .halted_q   (halted_q),
      .step       (step),
      .hc_clear   (hc_clear)
   );

   usbh_frm_counter #(
      .DATA_W  (DATA_W),
      .FRNUM_W (FRNUM_W),
      .IDX_W   (IDX_W),
      .ALIGN_W (ALIGN_W)
   ) u_counter (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (hc_clear),
      .step       (step),
      .halted     (halted_q),
      .fn_wr      (wr_fnum),
      .fn_wdata   (reg_wdata[FRNUM_W-1:0]),
      .base_wr    (wr_base),
      .base_wdata (reg_wdata[DATA_W-1:ALIGN_W]),
      .frnum_q    (frnum_q),
      .base_out   (base_q),
      .entry_addr (list_entry_addr)
   );

   usbh_frm_irq #(
      .REG_OUT (IRQ_REG)
   ) u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .sts   (sts_q),
      .hid   (hid_q),
      .ien   (ien_q),
      .irq   (irq)
   );

   assign halted = halted_q;

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == AW'(RA_CMD))       reg_rdata = DATA_W'(cmd_q);
      else if (reg_addr == AW'(RA_STS))  reg_rdata = DATA_W'({halted_q, sts_q});
      else if (reg_addr == AW'(RA_IEN))  reg_rdata = DATA_W'(ien_q);
      else if (reg_addr == AW'(RA_FNUM)) reg_rdata = DATA_W'(frnum_q);
      else if (reg_addr == AW'(RA_BASE)) reg_rdata = base_q;
   end

   // R6: the list entry always sits on a word boundary inside the base page
   p_entry_in_page_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (list_entry_addr[1:0] == 2'b00) && (list_entry_addr[DATA_W-1:ALIGN_W] == base_q[DATA_W-1:ALIGN_W]));

   // R1: halted and running never coexist with an unchanged command
   p_halt_tracks_run_r1: assert property (@(posedge clk) disable iff (!rst_n)
      halted_q == !cmd_q[CB_RUN]);

endmodule

// File: tb/usbh_frame_regs_bench.sv
module usbh_frame_regs_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        frame_tick = 1'b0, resume_req = 1'b0;
   logic        td_ioc = 1'b0, td_spd = 1'b0, td_err = 1'b0, sys_err = 1'b0, proc_err = 1'b0;
   logic        halted, irq;
   logic [31:0] list_entry_addr;

   int compared = 0;
   int mismatched = 0;

   always #10 clk = ~clk;

   usbh_frame_regs u_usbh_frame_regs (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frame_tick(frame_tick),
      .resume_req(resume_req), .td_ioc(td_ioc), .td_spd(td_spd), .td_err(td_err),
      .sys_err(sys_err), .proc_err(proc_err), .halted(halted),
      .list_entry_addr(list_entry_addr), .irq(irq)
   );

   // ---------------- reference model ----------------
   bit [31:0] m_cmd, m_sts, m_ien, m_fn, m_base, m_hid, m_pend;
   bit        m_halt, m_start;

   task automatic m_reset();
      m_cmd = 0; m_sts = 0; m_ien = 0; m_fn = 0; m_base = 0;
      m_hid = 0; m_pend = 0; m_halt = 1; m_start = 0;
   endtask

   function automatic bit [31:0] m_read(bit [2:0] a);
      case (a)
         3'd0: return m_cmd;
         3'd1: return m_sts | (32'(m_halt) << 5);
         3'd2: return m_ien;
         3'd3: return m_fn;
         3'd4: return m_base;
         default: return 0;
      endcase
   endfunction

   function automatic bit m_irq();
      return (m_hid[0] && m_ien[2]) || (m_hid[1] && m_ien[3]) ||
             (m_sts[1] && m_ien[0]) || (m_sts[2] && m_ien[1]) || m_sts[3] || m_sts[4];
   endfunction

   always @(posedge clk) begin
      bit [31:0] n_cmd, n_sts, n_hid, n_pend;
      bit        n_halt, n_start, stp;
      if (!rst_n) begin
         m_reset();
      end else if (reg_wr && reg_addr == 3'd0 && reg_wdata[1]) begin
         m_reset();
      end else begin
         stp     = m_start || (frame_tick && m_cmd[0]);
         n_cmd   = m_cmd; n_sts = m_sts; n_hid = m_hid; n_pend = m_pend;
         n_halt  = m_halt; n_start = 0;
         if (frame_tick && !m_cmd[0]) n_halt = 1;
         if (reg_wr) begin
            case (reg_addr)
               3'd0: begin
                  n_cmd = reg_wdata & 32'h1D;
                  if (reg_wdata[0] && !m_cmd[0]) begin n_halt = 0; n_start = 1; end
                  else if (!reg_wdata[0]) n_halt = 1;
               end
               3'd1: begin
                  n_sts = m_sts & ~(reg_wdata & 32'h1F);
                  if (reg_wdata[0]) n_hid = 0;
               end
               3'd2: m_ien = reg_wdata & 32'hF;
               3'd3: if (m_halt) m_fn = reg_wdata & 32'h7FF;
               3'd4: m_base = reg_wdata & 32'hFFFF_F000;
               default: ;
            endcase
         end
         if (stp) begin
            m_fn = (m_fn + 1) & 32'h7FF;
            if (m_pend != 0) begin n_hid |= m_pend; n_sts |= 1; end
            n_pend = 0;
         end
         n_pend |= {30'd0, td_spd, td_ioc};
         if (td_err)   n_sts |= 32'h02;
         if (sys_err)  n_sts |= 32'h08;
         if (proc_err) n_sts |= 32'h10;
         if (resume_req && m_cmd[3]) begin n_cmd |= 32'h10; n_sts |= 32'h04; end
         m_cmd = n_cmd; m_sts = n_sts; m_hid = n_hid; m_pend = n_pend;
         m_halt = n_halt; m_start = n_start;
      end
   end

   task automatic chk(string tag, bit [31:0] act, bit [31:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
      end
   endtask

   // every-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n) begin
         chk("R2 halted output", 32'(halted), 32'(m_halt));
         chk("R6 list entry address", list_entry_addr, m_base | ((m_fn & 32'h3FF) << 2));
         chk("R8 interrupt line", 32'(irq), 32'(m_irq()));
         chk("R9 read data", reg_rdata, m_read(reg_addr));
      end
   end

   // ---------------- drivers ----------------
   task automatic cyc();
      @(posedge clk); #2;
   endtask

   task automatic wr(bit [2:0] a, bit [31:0] d);
      cyc(); reg_wr = 1; reg_addr = a; reg_wdata = d;
      cyc(); reg_wr = 0;
   endtask

   task automatic rd(string tag, bit [2:0] a, bit [31:0] exp);
      reg_addr = a;
      @(negedge clk);
      chk(tag, reg_rdata, exp);
      #12;
   endtask

   task automatic tick();
      cyc(); frame_tick = 1; cyc(); frame_tick = 0;
   endtask

   task automatic ev(bit ioc, bit spd, bit err, bit hse, bit res);
      cyc(); td_ioc = ioc; td_spd = spd; td_err = err; sys_err = hse; resume_req = res;
      cyc(); td_ioc = 0; td_spd = 0; td_err = 0; sys_err = 0; resume_req = 0;
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      mismatched++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) cyc();
      rst_n = 1;
      cyc();
      // R1 reset state
      chk("R1 halted after reset", 32'(halted), 1);
      chk("R1 irq after reset", 32'(irq), 0);
      rd("R1 status reset", 3'd1, 32'h20);
      rd("R1 command reset", 3'd0, 0);
      rd("R1 frame number reset", 3'd3, 0);
      // R6 base alignment and entry address
      wr(3'd4, 32'h1234_5ABC);
      rd("R6 base low bits cleared", 3'd4, 32'h1234_5000);
      // R5 frame write while halted
      wr(3'd3, 32'hFFFF_F7FE);
      rd("R5 frame write while halted", 3'd3, 32'h7FE);
      chk("R6 entry address", list_entry_addr, 32'h1234_5FF8);
      // R4 ticks while stopped
      tick(); tick(); tick();
      rd("R4 frame number frozen while stopped", 3'd3, 32'h7FE);
      chk("R4 halted stays set", 32'(halted), 1);
      // R2 / R3 start
      wr(3'd2, 32'hF);
      wr(3'd0, 32'h1);
      chk("R2 run clears halted", 32'(halted), 0);
      cyc();
      rd("R3 start acts as a boundary", 3'd3, 32'h7FF);
      tick();
      rd("R3 wrap modulo 2048", 3'd3, 32'h000);
      chk("R6 entry after wrap", list_entry_addr, 32'h1234_5000);
      // R5 write ignored while running
      wr(3'd3, 32'h5);
      rd("R5 frame write ignored while running", 3'd3, 32'h0);
      // R7 pending posting
      ev(1, 0, 0, 0, 0);
      rd("R7 completion not posted before boundary", 3'd1, 32'h00);
      chk("R7 irq quiet before boundary", 32'(irq), 0);
      tick();
      rd("R7 completion posted at boundary", 3'd1, 32'h01);
      chk("R8 completion with enable bit 2", 32'(irq), 1);
      // R9 W1C
      wr(3'd1, 32'h1);
      rd("R9 interrupt flag cleared", 3'd1, 32'h00);
      chk("R9 hidden bits cleared", 32'(irq), 0);
      // R8 routing of hidden bits
      wr(3'd2, 32'h8);
      ev(1, 0, 0, 0, 0); tick();
      chk("R8 completion without its enable", 32'(irq), 0);
      ev(0, 1, 0, 0, 0); tick();
      chk("R8 short packet with enable bit 3", 32'(irq), 1);
      wr(3'd1, 32'h1);
      // R10 errors
      ev(0, 0, 1, 0, 0);
      rd("R10 transfer error sticky", 3'd1, 32'h02);
      chk("R8 transfer error masked", 32'(irq), 0);
      wr(3'd1, 32'h2);
      ev(0, 0, 0, 1, 0);
      rd("R10 system error sticky", 3'd1, 32'h08);
      chk("R8 system error unmasked", 32'(irq), 1);
      wr(3'd1, 32'h3F);
      rd("R9 halted bit not writable while running", 3'd1, 32'h00);
      // R11 resume
      ev(0, 0, 0, 0, 1);
      rd("R11 resume ignored without suspend", 3'd0, 32'h01);
      wr(3'd0, 32'h9);
      ev(0, 0, 0, 0, 1);
      rd("R11 resume sets force resume", 3'd0, 32'h19);
      rd("R11 resume detect status", 3'd1, 32'h04);
      wr(3'd2, 32'h2);
      chk("R8 resume detect with enable bit 1", 32'(irq), 1);
      // R2 stop, R9 halted read-only
      wr(3'd0, 32'h0);
      chk("R2 stop sets halted", 32'(halted), 1);
      wr(3'd1, 32'h20);
      rd("R9 halted bit ignores writes", 3'd1, 32'h24);
      // R12 controller reset
      wr(3'd0, 32'h6);
      rd("R12 command cleared", 3'd0, 32'h0);
      rd("R12 status default", 3'd1, 32'h20);
      rd("R12 enable cleared", 3'd2, 32'h0);
      rd("R12 base cleared", 3'd4, 32'h0);
      chk("R12 irq low", 32'(irq), 0);
      // R12 global reset bit stored
      wr(3'd0, 32'h4);
      rd("R12 global reset bit stored", 3'd0, 32'h4);

      // random traffic compared against the model each cycle
      for (int i = 0; i < 4000; i++) begin
         bit [31:0] r, d;
         r = $urandom;
         d = $urandom;
         cyc();
         reg_wr   = r[0] & r[1];
         reg_addr = r[4:2];
         if (r[4:2] == 3'd0 && r[9:5] != 0) d[1] = 1'b0;
         if (r[4:2] == 3'd0 && r[8:7] != 0) d[0] = 1'b1;
         reg_wdata  = d;
         frame_tick = (r[12:10] == 0);
         resume_req = (r[15:13] == 0);
         td_ioc     = (r[18:16] == 0);
         td_spd     = (r[21:19] == 0);
         td_err     = (r[24:22] == 0);
         sys_err    = (r[27:25] == 0) && r[31];
         proc_err   = (r[30:28] == 0) && r[31];
      end
      cyc();
      reg_wr = 0; frame_tick = 0; resume_req = 0;
      td_ioc = 0; td_spd = 0; td_err = 0; sys_err = 0; proc_err = 0;
      repeat (3) cyc();
      finish_run();
   end

endmodule